// File: doc/BRIEF.md
# Byte FIFO Handshake Port

This block is the device end of an eight-bit parallel byte port that a host drives with two strobes. The host reads and writes bytes over a shared data bus. It paces itself on two active-low flags: "data available", which means the device has a byte for the host, and "space available", which means the device can accept a byte from the host. Inside the block sit two small queues. One holds bytes that the surrounding system has handed over for the host. The other holds bytes that the host has written and that the system has not yet consumed. On the system side both queues use a plain valid/ready handshake.

The host strobes are asynchronous to the system clock. Each passes through a flop synchronizer and an edge detector, so one strobe pulse causes exactly one transfer however long it lasts.

- A falling read strobe takes the oldest queued byte into an output holder. The block drives the bus only while the synchronized read strobe is low.
- A falling write strobe captures the bus into the inbound queue.
- After every strobe the matching flag stays inactive for a programmable number of clocks. The host therefore has to see each flag cycle before it starts the next transfer.

All timing is counted in system clock cycles. The bus appears at the ports as separate in, out and enable vectors, and the pad joins them outside this block.

Top module: `pfifo_host_port`

## Requirements
- R1: After reset, avail_n is 1, space_n is 0, host_d_oe is 0, snk_valid is 0 and src_ready is 1.
- R2: avail_n is 0 exactly when the outbound queue holds at least one byte and no read holdoff is running. A byte accepted on src_valid & src_ready with no holdoff running makes avail_n 0 right after that clock edge.
- R3: A falling read strobe is acted on at the third rising edge after host_rd_n goes low. At that edge host_d_oe becomes 1 and host_d_o shows the oldest queued byte, in arrival order. host_d_oe returns to 0 at the third rising edge after host_rd_n goes high, and it is 0 at every other time.
- R4: From the fetch edge, avail_n is 1 while the strobe is held low. It stays 1 for RD_GAP (default 2) clocks after the synchronized strobe rises, even if more bytes are queued. With defaults, avail_n can fall again at the fourth rising edge after host_rd_n goes high.
- R5: A read strobe that falls while avail_n is 1 removes nothing from the queue. host_d_o shows the previous byte again.
- R6: space_n is 0 exactly when the inbound queue is not full and no write holdoff is running.
- R7: A falling host_wr captures host_d_i into the inbound queue at the third rising edge after host_wr goes low. The byte then shows on snk_data / snk_valid in arrival order.
- R8: After a write capture, space_n is 1 for at least WR_GAP (default 2) clocks. It is still 1 at the fourth rising edge after host_wr falls.
- R9: A falling host_wr while space_n is 1 is ignored: no byte enters the inbound queue.
- R10: A strobe held active for many clocks causes exactly one transfer.
- R11: src_ready is 0 while the outbound queue is full, and a byte offered then is not taken. snk_valid is 0 when the inbound queue is empty. A byte leaves the inbound queue on snk_valid & snk_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_data | input | DATA_W | Byte from the system, bound for the host |
| src_valid | input | 1 | src_data is offered |
| src_ready | output | 1 | Outbound queue can take a byte |
| snk_data | output | DATA_W | Oldest byte written by the host |
| snk_valid | output | 1 | snk_data holds a byte |
| snk_ready | input | 1 | System takes snk_data |
| host_rd_n | input | 1 | Host read strobe, active low, idles high |
| host_wr | input | 1 | Host write strobe, idles low, capture on falling edge |
| host_d_i | input | DATA_W | Bus value seen at the pad |
| host_d_o | output | DATA_W | Byte driven to the pad |
| host_d_oe | output | 1 | Pad output enable for host_d_o |
| avail_n | output | 1 | Active-low: a byte may be read |
| space_n | output | 1 | Active-low: a byte may be written |

## Verification
The bench changes the strobes at falling clock edges and counts rising edges from there.

| Result | Due at rising edge after the strobe change |
|---|---|
| Bus enabled, outbound byte shown | Third after host_rd_n falls |
| Bus released | Third after host_rd_n rises |
| avail_n may fall again | Fourth after host_rd_n rises |
| Host byte in the inbound queue | Third after host_wr falls |
| space_n may fall again | Fifth after host_wr falls |

Each check samples one nanosecond after the edge it names. The bench also samples the edge before the fetch, so an early bus drive is reported as well as a late one. The queue-effect checks are made at the ports: ignored strobes and holdoff behaviour are judged by reading or pulling the following bytes and comparing them with the expected order.

// File: rtl/pfp_pkg.sv
package pfp_pkg;

   // Synchronized strobe as seen by the clocked logic.
   typedef struct packed {
      logic level;   // synchronized pin level
      logic fall;    // one-cycle pulse on a high-to-low transition
   } strobe_t;

endpackage

// File: rtl/pfp_strobe_sync.sv
module pfp_strobe_sync
   import pfp_pkg::*;
#(
   parameter int STAGES = 2,
   parameter bit IDLE   = 1'b1
) (
   input  logic    clk,
   input  logic    rst_n,
   input  logic    pin,
   output strobe_t strb
);

   logic [STAGES-1:0] chain_q;
   logic              last_q;

   initial begin
      assert (STAGES >= 2) else $error("pfp_strobe_sync: STAGES must be at least 2");
   end

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= IDLE;
               else        chain_q[0] <= pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[g] <= IDLE;
               else        chain_q[g] <= chain_q[g-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= IDLE;
      else        last_q <= chain_q[STAGES-1];
   end

   assign strb.level = chain_q[STAGES-1];
   assign strb.fall  = last_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/pfp_gap_timer.sv
module pfp_gap_timer #(
   parameter int GAP = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic hold,
   output logic busy
);

   localparam int CW = $clog2(GAP + 1);

   logic [CW-1:0] cnt_q;

   initial begin
      assert (GAP >= 1) else $error("pfp_gap_timer: GAP must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start) begin
         cnt_q <= CW'(GAP);
      end else if (!hold && cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy = (cnt_q != '0);

endmodule

// File: rtl/pfp_sync_fifo.sv
module pfp_sync_fifo #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic              empty,
   output logic              full
);

   initial begin
      assert (DEPTH >= 1) else $error("pfp_sync_fifo: DEPTH must be at least 1");
      assert ((DEPTH & (DEPTH - 1)) == 0) else $error("pfp_sync_fifo: DEPTH must be a power of two");
      assert (DATA_W >= 1) else $error("pfp_sync_fifo: DATA_W must be at least 1");
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [DATA_W-1:0] data_q;
         logic              occ_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               occ_q <= 1'b0;
            end else if (push && !occ_q) begin
               occ_q <= 1'b1;
            end else if (pop && occ_q) begin
               occ_q <= 1'b0;
            end
         end

         always_ff @(posedge clk) begin
            if (push && !occ_q) data_q <= din;
         end

         assign dout  = data_q;
         assign empty = ~occ_q;
         assign full  = occ_q;
      end else begin : g_ring
         localparam int PTR_W = $clog2(DEPTH);
         localparam int CNT_W = $clog2(DEPTH + 1);

         logic [DATA_W-1:0] mem_q [DEPTH];
         logic [PTR_W-1:0]  wr_ptr_q;
         logic [PTR_W-1:0]  rd_ptr_q;
         logic [CNT_W-1:0]  cnt_q;
         logic              push_ok;
         logic              pop_ok;

         assign push_ok = push & ~full;
         assign pop_ok  = pop & ~empty;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_ptr_q <= '0;
               rd_ptr_q <= '0;
               cnt_q    <= '0;
            end else begin
               if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
               if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
               case ({push_ok, pop_ok})
                  2'b10:   cnt_q <= cnt_q + 1'b1;
                  2'b01:   cnt_q <= cnt_q - 1'b1;
                  default: cnt_q <= cnt_q;
               endcase
            end
         end

         always_ff @(posedge clk) begin
            if (push_ok) mem_q[wr_ptr_q] <= din;
         end

         assign dout  = mem_q[rd_ptr_q];
         assign empty = (cnt_q == '0);
         assign full  = (cnt_q == CNT_W'(DEPTH));
      end
   endgenerate

endmodule

// File: rtl/pfifo_host_port.sv
module pfifo_host_port
   import pfp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int RX_DEPTH    = 4,
   parameter int TX_DEPTH    = 4,
   parameter int SYNC_STAGES = 2,
   parameter int RD_GAP      = 2,
   parameter int WR_GAP      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] src_data,
   input  logic              src_valid,
   output logic              src_ready,
   output logic [DATA_W-1:0] snk_data,
   output logic              snk_valid,
   input  logic              snk_ready,
   input  logic              host_rd_n,
   input  logic              host_wr,
   input  logic [DATA_W-1:0] host_d_i,
   output logic [DATA_W-1:0] host_d_o,
   output logic              host_d_oe,
   output logic              avail_n,
   output logic              space_n
);

   initial begin
      assert (RD_GAP >= 2) else $error("pfifo_host_port: RD_GAP below two clocks");
      assert (WR_GAP >= 1) else $error("pfifo_host_port: WR_GAP must be at least 1");
      assert (SYNC_STAGES >= 2) else $error("pfifo_host_port: SYNC_STAGES below two");
   end

   // Strobe synchronizers: read idles high, write idles low.
   strobe_t rd_s;
   strobe_t wr_s;

   pfp_strobe_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b1)) u_rd_sync (
      .clk(clk), .rst_n(rst_n), .pin(host_rd_n), .strb(rd_s));

   pfp_strobe_sync #(.STAGES(SYNC_STAGES), .IDLE(1'b0)) u_wr_sync (
      .clk(clk), .rst_n(rst_n), .pin(host_wr), .strb(wr_s));

   // Outbound path: system -> queue -> host.
   logic              rx_push;
   logic              rx_pop;
   logic              rx_empty;
   logic              rx_full;
   logic [DATA_W-1:0] rx_head;
   logic              rd_busy;
   logic [DATA_W-1:0] rd_hold_q;
   logic              oe_q;

   assign rx_push   = src_valid & ~rx_full;
   assign src_ready = ~rx_full;
   assign rx_pop    = rd_s.fall & ~avail_n;
   assign avail_n   = rx_empty | rd_busy;

   pfp_sync_fifo #(.DATA_W(DATA_W), .DEPTH(RX_DEPTH)) u_rx_q (
      .clk(clk), .rst_n(rst_n),
      .push(rx_push), .din(src_data),
      .pop(rx_pop), .dout(rx_head),
      .empty(rx_empty), .full(rx_full));

   // Read holdoff: armed on every fetch attempt, frozen while the strobe is low.
   pfp_gap_timer #(.GAP(RD_GAP)) u_rd_gap (
      .clk(clk), .rst_n(rst_n),
      .start(rd_s.fall), .hold(~rd_s.level), .busy(rd_busy));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_hold_q <= '0;
         oe_q      <= 1'b0;
      end else begin
         if (rx_pop) rd_hold_q <= rx_head;
         oe_q <= ~rd_s.level;
      end
   end

   assign host_d_o  = rd_hold_q;
   assign host_d_oe = oe_q;

   // Inbound path: host -> queue -> system.
   logic tx_push;
   logic tx_pop;
   logic tx_empty;
   logic tx_full;
   logic wr_busy;

   assign space_n   = tx_full | wr_busy;
   assign tx_push   = wr_s.fall & ~space_n;
   assign tx_pop    = snk_ready & ~tx_empty;
   assign snk_valid = ~tx_empty;

   pfp_sync_fifo #(.DATA_W(DATA_W), .DEPTH(TX_DEPTH)) u_tx_q (
      .clk(clk), .rst_n(rst_n),
      .push(tx_push), .din(host_d_i),
      .pop(tx_pop), .dout(snk_data),
      .empty(tx_empty), .full(tx_full));

   // Write holdoff: armed on every falling write strobe, frozen if a new pulse is already high.
   pfp_gap_timer #(.GAP(WR_GAP)) u_wr_gap (
      .clk(clk), .rst_n(rst_n),
      .start(wr_s.fall), .hold(wr_s.level), .busy(wr_busy));

endmodule

// File: rtl/pfifo_host_port_chk.sv
module pfifo_host_port_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              host_rd_n,
   input logic [DATA_W-1:0] host_d_o,
   input logic              host_d_oe,
   input logic              avail_n,
   input logic              space_n,
   input logic              rd_fall,
   input logic              rd_level,
   input logic              rx_pop,
   input logic              tx_push,
   input logic              tx_full
);

   // Clocks since reset release, saturating at the bus-window depth.
   logic [1:0] since_rst_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 since_rst_q <= 2'd0;
      else if (since_rst_q != 2'd3) since_rst_q <= since_rst_q + 2'd1;
   end

   // R3: bus is enabled exactly three clocks after the pin goes low.
   assert_bus_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst_q == 2'd3) |-> (host_d_oe == !$past(host_rd_n, 3)));

   // R4: flag hidden right after a fetch attempt.
   assert_fetch_hides_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fall |=> avail_n);

   // R4: flag still hidden in the first clock after the strobe rises.
   assert_release_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_level) |=> avail_n);

   // R5: a fetch attempt while the flag is high leaves the output byte unchanged.
   assert_stale_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_fall && avail_n) |=> $stable(host_d_o));

   // R8: space flag goes inactive after every capture.
   assert_write_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |=> space_n);

   // R9: no capture into a full inbound queue.
   assert_no_overfill_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_push |-> !tx_full);

   // R10: one pulse, one pop.
   assert_single_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pop |=> !rx_pop);

endmodule

bind pfifo_host_port pfifo_host_port_chk #(.DATA_W(DATA_W)) chk_i (
   .clk(clk),
   .rst_n(rst_n),
   .host_rd_n(host_rd_n),
   .host_d_o(host_d_o),
   .host_d_oe(host_d_oe),
   .avail_n(avail_n),
   .space_n(space_n),
   .rd_fall(rd_s.fall),
   .rd_level(rd_s.level),
   .rx_pop(rx_pop),
   .tx_push(tx_push),
   .tx_full(tx_full)
);

// File: tb/pfifo_host_port_tb_top.sv
`timescale 1ns/1ps
module pfifo_host_port_tb_top;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [7:0] src_data;
   logic       src_valid;
   logic       src_ready;
   logic [7:0] snk_data;
   logic       snk_valid;
   logic       snk_ready;
   logic       host_rd_n;
   logic       host_wr;
   logic [7:0] host_d_i;
   logic [7:0] host_d_o;
   logic       host_d_oe;
   logic       avail_n;
   logic       space_n;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   pfifo_host_port dut_i (
      .clk(clk), .rst_n(rst_n),
      .src_data(src_data), .src_valid(src_valid), .src_ready(src_ready),
      .snk_data(snk_data), .snk_valid(snk_valid), .snk_ready(snk_ready),
      .host_rd_n(host_rd_n), .host_wr(host_wr),
      .host_d_i(host_d_i), .host_d_o(host_d_o), .host_d_oe(host_d_oe),
      .avail_n(avail_n), .space_n(space_n));

   // bit 8: 1 = host writes the byte, 0 = system sends it to the host
   localparam logic [8:0] VEC [6] = '{9'h0A5, 9'h13C, 9'h0FF, 9'h100, 9'h07E, 9'h181};

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic sys_push(input logic [7:0] b);
      @(negedge clk);
      src_data  = b;
      src_valid = 1'b1;
      tick(1);
      @(negedge clk);
      src_valid = 1'b0;
   endtask

   task automatic sys_pull(input logic [7:0] exp, input string tag);
      chk({tag, " snk_valid"}, 32'(snk_valid), 32'd1);
      chk({tag, " snk_data"}, 32'(snk_data), 32'(exp));
      @(negedge clk);
      snk_ready = 1'b1;
      tick(1);
      @(negedge clk);
      snk_ready = 1'b0;
   endtask

   task automatic host_read(input logic [7:0] exp, input logic exp_avail, input string tag);
      @(negedge clk);
      host_rd_n = 1'b0;
      tick(2);
      chk({tag, " R3 bus not yet driven"}, 32'(host_d_oe), 32'd0);
      tick(1);
      chk({tag, " R3 bus driven"}, 32'(host_d_oe), 32'd1);
      chk({tag, " R3 byte"}, 32'(host_d_o), 32'(exp));
      chk({tag, " R4 flag hidden after fetch"}, 32'(avail_n), 32'd1);
      tick(4);
      chk({tag, " R3 bus held"}, 32'(host_d_oe), 32'd1);
      @(negedge clk);
      host_rd_n = 1'b1;
      tick(3);
      chk({tag, " R3 bus released"}, 32'(host_d_oe), 32'd0);
      chk({tag, " R4 flag in holdoff"}, 32'(avail_n), 32'd1);
      tick(1);
      chk({tag, " R2 flag after holdoff"}, 32'(avail_n), 32'(exp_avail));
   endtask

   task automatic host_write(input logic [7:0] b, input logic exp_valid,
                             input logic exp_space, input string tag);
      @(negedge clk);
      host_d_i = b;
      host_wr  = 1'b1;
      tick(4);
      @(negedge clk);
      host_wr = 1'b0;
      tick(3);
      chk({tag, " R7 snk_valid"}, 32'(snk_valid), 32'(exp_valid));
      chk({tag, " R8 space hidden"}, 32'(space_n), 32'd1);
      tick(1);
      chk({tag, " R8 space still hidden"}, 32'(space_n), 32'd1);
      tick(1);
      chk({tag, " R6 space after holdoff"}, 32'(space_n), 32'(exp_space));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] last_rd;
      rst_n     = 1'b0;
      src_data  = '0;
      src_valid = 1'b0;
      snk_ready = 1'b0;
      host_rd_n = 1'b1;
      host_wr   = 1'b0;
      host_d_i  = '0;
      last_rd   = '0;
      tick(4);
      @(negedge clk);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      chk("R1 avail_n", 32'(avail_n), 32'd1);
      chk("R1 space_n", 32'(space_n), 32'd0);
      chk("R1 host_d_oe", 32'(host_d_oe), 32'd0);
      chk("R1 snk_valid", 32'(snk_valid), 32'd0);
      chk("R1 src_ready", 32'(src_ready), 32'd1);

      // Table walk: R2 R3 R7 R11
      for (int i = 0; i < 6; i++) begin
         if (VEC[i][8]) begin
            host_write(VEC[i][7:0], 1'b1, 1'b0, "vec write");
            sys_pull(VEC[i][7:0], "vec R7 pull");
            tick(1);
            chk("vec R11 inbound empty", 32'(snk_valid), 32'd0);
         end else begin
            sys_push(VEC[i][7:0]);
            chk("vec R2 avail after push", 32'(avail_n), 32'd0);
            host_read(VEC[i][7:0], 1'b1, "vec read");
            last_rd = VEC[i][7:0];
         end
      end

      // R4: flag cycles between reads even with bytes queued
      sys_push(8'h31);
      sys_push(8'h32);
      sys_push(8'h33);
      host_read(8'h31, 1'b0, "order R4 first");
      host_read(8'h32, 1'b0, "order R4 second");
      host_read(8'h33, 1'b1, "order R4 third");

      // R5: read with nothing queued repeats the old byte and pops nothing
      host_read(8'h33, 1'b1, "stale R5");
      sys_push(8'h44);
      host_read(8'h44, 1'b1, "after stale R5");

      // R10: long read pulse fetches once
      sys_push(8'h51);
      sys_push(8'h52);
      @(negedge clk);
      host_rd_n = 1'b0;
      tick(40);
      chk("R10 long read byte", 32'(host_d_o), 32'h51);
      @(negedge clk);
      host_rd_n = 1'b1;
      tick(4);
      chk("R10 second byte still queued", 32'(avail_n), 32'd0);
      host_read(8'h52, 1'b1, "R10 next read");

      // R10: long write pulse captures once
      @(negedge clk);
      host_d_i = 8'h5A;
      host_wr  = 1'b1;
      tick(30);
      @(negedge clk);
      host_wr = 1'b0;
      tick(30);
      sys_pull(8'h5A, "R10 long write");
      tick(1);
      chk("R10 single capture", 32'(snk_valid), 32'd0);

      // R6 R9: fill inbound queue, extra write dropped
      host_write(8'h10, 1'b1, 1'b0, "fill 0");
      host_write(8'h11, 1'b1, 1'b0, "fill 1");
      host_write(8'h12, 1'b1, 1'b0, "fill 2");
      host_write(8'h13, 1'b1, 1'b1, "fill 3 R6 full");
      host_write(8'hEE, 1'b1, 1'b1, "R9 ignored write");
      sys_pull(8'h10, "R9 drain 0");
      chk("R6 space back after pop", 32'(space_n), 32'd0);
      sys_pull(8'h11, "R9 drain 1");
      sys_pull(8'h12, "R9 drain 2");
      sys_pull(8'h13, "R9 drain 3");
      tick(1);
      chk("R9 dropped byte absent", 32'(snk_valid), 32'd0);

      // R11: outbound queue full refuses bytes
      sys_push(8'h60);
      sys_push(8'h61);
      sys_push(8'h62);
      sys_push(8'h63);
      chk("R11 src_ready low when full", 32'(src_ready), 32'd0);
      sys_push(8'h99);
      host_read(8'h60, 1'b0, "R11 read 0");
      host_read(8'h61, 1'b0, "R11 read 1");
      host_read(8'h62, 1'b0, "R11 read 2");
      host_read(8'h63, 1'b1, "R11 read 3 refused byte absent");
      chk("R11 src_ready back", 32'(src_ready), 32'd1);

      tick(2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule